// File: doc/BRIEF.md
# Position Read Frame Formatter

This block answers the position-read opcode (0xA6) of a four-wire serial port that runs in clock-idle-low mode, sampling on the rising edge and launching on the falling edge. The block runs on a fast system clock and oversamples the serial clock. During the first eight serial clocks it mirrors the host's opcode bits back onto the data-out line. It also captures the multi-turn and single-turn position, the alarm and warning state and the frame configuration on the first rising serial edge. When the opcode turns out to be 0xA6, it streams a response frame most-significant bit first. The frame carries the multi-turn word, the single-turn word at a selectable width, an active-low error flag and an active-low warning flag. It ends with either a 6-bit CRC, or a 6-bit read sequence number followed by a 16-bit CRC.

The CRC is computed serially, one bit per launched data bit, starting from a programmable seed. It is then shifted out directly behind the data. A 6-bit read counter advances on every recognised position read, and that counter is what the long format reports. Any other opcode gets the echo and then a quiet line.

Top module: `pos_frame_fmt`

## Requirements
- R1: While `spi_cs_n` is high, `spi_miso_oe` is 0 and `spi_miso` is 0; while it is low, `spi_miso_oe` is 1.
- R2: For serial bits 0 to 7 of a frame, `spi_miso` equals `spi_mosi` (opcode echo).
- R3: Position, flags, format, width select and CRC seed are captured on the first rising serial edge of a frame; changes to those inputs after that edge do not alter the frame.
- R4: After the opcode, a 0xA6 frame sends the multi-turn word (MT_W bits), then the single-turn word with width 15, 16, 17 or 18 bits for `st_sel` = 0, 1, 2, 3 (lowest bits of `st_pos`), MSB first.
- R5: The error flag bit follows the single-turn field and is 0 when any bit of `alarm_vec & alarm_en` is 1, else 1; the warning flag bit comes next and is formed the same way from `warn_vec & warn_en`.
- R6: With `ext_fmt`=1, a 6-bit sequence number follows the warning flag; it equals the count of earlier 0xA6 frames since reset modulo 64 (reads in both formats count, other opcodes do not).
- R7: With `ext_fmt`=0, a 6-bit CRC with polynomial x^6+x+1 follows the warning flag; its register is seeded with `crc_seed[5:0]`, fed MSB first with every bit after the opcode up to the CRC, and sent MSB first.
- R8: With `ext_fmt`=1, a 16-bit CRC with polynomial x^16+x^15+x^12+x^7+x^6+x^4+x^3+1 (0x90D9) seeded with `crc_seed` covers the same span including the sequence number and is sent MSB first.
- R9: For any opcode other than 0xA6, `spi_miso` is 0 for every bit after the eighth.
- R10: Every bit after the last CRC bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Host data in |
| spi_miso | output | 1 | Data out |
| spi_miso_oe | output | 1 | Output enable for the data-out driver |
| mt_pos | input | MT_W | Multi-turn position |
| st_pos | input | 18 | Single-turn position, right-justified |
| st_sel | input | 2 | Single-turn width select |
| ext_fmt | input | 1 | 0: short frame with 6-bit CRC, 1: long frame with sequence and 16-bit CRC |
| crc_seed | input | 16 | CRC initial value |
| alarm_vec | input | 32 | Raw alarm bits |
| alarm_en | input | 32 | Alarm enable mask |
| warn_vec | input | 32 | Raw warning bits |
| warn_en | input | 32 | Warning enable mask |

## Verification
The bench goes after the variable single-turn width. A packer that aligned the tail wrongly would shift the flags and the CRC by one to three bits and corrupt every frame at a narrow width. It changes every input right after the first rising edge, so a design that sampled late would leak the new position into the frame. It also runs more than 64 reads with foreign opcodes mixed in: a counter that skipped the wrap, or that counted non-position frames, would report the wrong sequence. Finally, nonzero seeds in both formats catch a CRC that ignores the seed, covers the wrong span or sends its bits in the wrong order.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int ST_MIN  = 15;
    localparam int ST_MAX  = ST_MIN + 3;
    localparam int SEQ_W   = 6;
    localparam int FLAG_W  = 32;
    localparam int CRC_S_W = 6;
    localparam int CRC_L_W = 16;

    localparam logic [7:0]         OPC_POS    = 8'hA6;
    localparam logic [CRC_S_W-1:0] POLY_SHORT = 6'h03;
    localparam logic [CRC_L_W-1:0] POLY_LONG  = 16'h90D9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_BODY,
        PH_CRC,
        PH_QUIET
    } phase_e;

    typedef struct packed {
        logic       long_fmt;
        logic [4:0] st_len;
    } frame_cfg_t;

    function automatic logic [4:0] st_width(input logic [1:0] sel);
        return 5'(ST_MIN) + {3'b000, sel};
    endfunction

endpackage

// File: rtl/pff_sck_edge.sv
module pff_sck_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;

endmodule

// File: rtl/pff_crc_serial.sv
module pff_crc_serial #(
    parameter int           W    = 6,
    parameter logic [W-1:0] POLY = 6'h03
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    input  logic         din,
    input  logic         shift,
    output logic [W-1:0] crc
);
    logic fb;
    assign fb = din ^ crc[W-1];

    always_ff @(posedge clk) begin
        if (rst)        crc <= '0;
        else if (load)  crc <= seed;
        else if (step)  crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        else if (shift) crc <= {crc[W-2:0], 1'b0};
    end

    AST_CRC_ONE_OP: assert property (@(posedge clk) disable iff (rst)
        !(step && shift) && !(load && (step || shift))); // R7

endmodule

// File: rtl/pff_seq_ctr.sv
module pff_seq_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (adv) count <= count + 1'b1;
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == W'($past(count) + 1'b1))); // R6

endmodule

// File: rtl/pos_frame_fmt.sv
module pos_frame_fmt
    import pff_pkg::*;
#(
    parameter int MT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_cs_n,
    input  logic                 spi_sck,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    output logic                 spi_miso_oe,
    input  logic [MT_W-1:0]      mt_pos,
    input  logic [ST_MAX-1:0]    st_pos,
    input  logic [1:0]           st_sel,
    input  logic                 ext_fmt,
    input  logic [CRC_L_W-1:0]   crc_seed,
    input  logic [FLAG_W-1:0]    alarm_vec,
    input  logic [FLAG_W-1:0]    alarm_en,
    input  logic [FLAG_W-1:0]    warn_vec,
    input  logic [FLAG_W-1:0]    warn_en
);
    localparam int TW = ST_MAX + 2 + SEQ_W;
    localparam int DW = MT_W + TW;
    localparam int LW = $clog2(DW + 1);

    phase_e          phase;
    frame_cfg_t      cfg_q, cfg_now;
    logic [2:0]      bit_cnt;
    logic [6:0]      opc_sr;
    logic [DW-1:0]   body_sr;
    logic [LW-1:0]   body_left;
    logic [4:0]      crc_left;
    logic            miso_q;

    logic            rise, fall;
    logic [SEQ_W-1:0] seq_cnt;
    logic [CRC_S_W-1:0] crc_s;
    logic [CRC_L_W-1:0] crc_l;

    pff_sck_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .rise (rise),
        .fall (fall)
    );

    // capture strobes
    logic first_rise, last_opc_rise, opc_match;
    assign first_rise    = (phase == PH_OPC) && rise && (bit_cnt == 3'd0);
    assign last_opc_rise = (phase == PH_OPC) && rise && (bit_cnt == 3'd7);
    assign opc_match     = ({opc_sr, spi_mosi} == OPC_POS);

    // frame word assembly
    logic            nerr_now, nwarn_now;
    logic [ST_MAX-1:0] st_mask;
    logic [4:0]      st_gap;
    logic [TW-1:0]   tail_raw, tail_al;
    logic [DW-1:0]   word_now;
    logic [LW-1:0]   len_now;

    always_comb begin
        cfg_now.long_fmt = ext_fmt;
        cfg_now.st_len   = st_width(st_sel);
        nerr_now  = ~|(alarm_vec & alarm_en);
        nwarn_now = ~|(warn_vec & warn_en);
        st_mask   = ~({ST_MAX{1'b1}} << cfg_now.st_len);
        st_gap    = 5'(ST_MAX) - cfg_now.st_len;
        tail_raw  = {st_pos & st_mask, nerr_now, nwarn_now, seq_cnt};
        tail_al   = tail_raw << st_gap;
        word_now  = {mt_pos, tail_al};
        len_now   = LW'(MT_W) + LW'(cfg_now.st_len) + LW'(2)
                  + (ext_fmt ? LW'(SEQ_W) : LW'(0));
    end

    // CRC engines, fed with the bit being launched
    logic crc_load, crc_step, crc_shift, crc_msb;
    assign crc_load  = first_rise;
    assign crc_step  = (phase == PH_BODY) && fall;
    assign crc_shift = (phase == PH_CRC) && fall;
    assign crc_msb   = cfg_q.long_fmt ? crc_l[CRC_L_W-1] : crc_s[CRC_S_W-1];

    pff_crc_serial #(.W(CRC_S_W), .POLY(POLY_SHORT)) u_crc_short (
        .clk   (clk),
        .rst   (rst),
        .load  (crc_load),
        .seed  (crc_seed[CRC_S_W-1:0]),
        .step  (crc_step),
        .din   (body_sr[DW-1]),
        .shift (crc_shift),
        .crc   (crc_s)
    );

    pff_crc_serial #(.W(CRC_L_W), .POLY(POLY_LONG)) u_crc_long (
        .clk   (clk),
        .rst   (rst),
        .load  (crc_load),
        .seed  (crc_seed),
        .step  (crc_step),
        .din   (body_sr[DW-1]),
        .shift (crc_shift),
        .crc   (crc_l)
    );

    pff_seq_ctr #(.W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .adv   (last_opc_rise && opc_match),
        .count (seq_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg_q     <= '0;
            bit_cnt   <= '0;
            opc_sr    <= '0;
            body_sr   <= '0;
            body_left <= '0;
            crc_left  <= '0;
            miso_q    <= 1'b0;
        end else if (spi_cs_n) begin
            phase  <= PH_IDLE;
            miso_q <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase   <= PH_OPC;
                    bit_cnt <= '0;
                    miso_q  <= 1'b0;
                end
                PH_OPC: if (rise) begin
                    opc_sr  <= {opc_sr[5:0], spi_mosi};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd0) begin
                        body_sr   <= word_now;
                        body_left <= len_now;
                        cfg_q     <= cfg_now;
                    end
                    if (bit_cnt == 3'd7) begin
                        phase  <= opc_match ? PH_BODY : PH_QUIET;
                        miso_q <= 1'b0;
                    end
                end
                PH_BODY: if (fall) begin
                    miso_q    <= body_sr[DW-1];
                    body_sr   <= body_sr << 1;
                    body_left <= body_left - 1'b1;
                    if (body_left == LW'(1)) begin
                        phase    <= PH_CRC;
                        crc_left <= cfg_q.long_fmt ? 5'(CRC_L_W) : 5'(CRC_S_W);
                    end
                end
                PH_CRC: if (fall) begin
                    miso_q   <= crc_msb;
                    crc_left <= crc_left - 5'd1;
                    if (crc_left == 5'd1) phase <= PH_QUIET;
                end
                PH_QUIET: if (fall) miso_q <= 1'b0;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign spi_miso_oe = ~spi_cs_n;
    assign spi_miso    = spi_cs_n ? 1'b0 : ((phase == PH_OPC) ? spi_mosi : miso_q);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> (!spi_miso && !spi_miso_oe)); // R1

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_BODY || phase == PH_CRC) && $past(phase == PH_BODY || phase == PH_CRC))
        |-> $stable(cfg_q)); // R3

    AST_CRC_AFTER_BODY: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_CRC) |-> (body_left == '0)); // R4

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_QUIET && fall && !spi_cs_n) |=> !miso_q); // R10

endmodule

// File: tb/pos_frame_fmt_bench.sv
`timescale 1ns/1ps
module pos_frame_fmt_bench;
    localparam int MT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe;
    logic [MT_W-1:0] mt;
    logic [17:0] st;
    logic [1:0]  sel;
    logic        ext;
    logic [15:0] seed;
    logic [31:0] alm, alm_en, wrn, wrn_en;

    always #2.5 clk = ~clk;

    pos_frame_fmt #(.MT_W(MT_W)) u_pos_frame_fmt (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .mt_pos(mt), .st_pos(st),
        .st_sel(sel), .ext_fmt(ext), .crc_seed(seed), .alarm_vec(alm),
        .alarm_en(alm_en), .warn_vec(wrn), .warn_en(wrn_en));

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int seq_model = 0;
    logic [0:127] rxv, exv;
    int f_mt, f_st, f_ne, f_nw, f_seq, f_crc, f_end;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] slice(input logic [0:127] v, input int lo, input int hi);
        logic [127:0] r = '0;
        for (int i = lo; i < hi; i++) r = {r[126:0], v[i]};
        return r;
    endfunction

    task automatic cmp(input int lo, input int hi, input string tag);
        logic [127:0] a, e;
        a = slice(rxv, lo, hi);
        e = slice(exv, lo, hi);
        chk(a == e, tag, a, e);
    endtask

    // expected frame from the requirements
    task automatic build(input logic [7:0] op, input int nbits);
        int idx = 0;
        int len;
        logic ne, nw;
        logic [5:0] c6;
        logic [15:0] c16;
        exv = '0;
        for (int i = 7; i >= 0; i--) begin exv[idx] = op[i]; idx++; end
        if (op != 8'hA6) begin
            f_end = 8;
            return;
        end
        len = 15 + int'(sel);
        ne = ~|(alm & alm_en);
        nw = ~|(wrn & wrn_en);
        f_mt = idx;
        for (int i = MT_W - 1; i >= 0; i--) begin exv[idx] = mt[i]; idx++; end
        f_st = idx;
        for (int i = len - 1; i >= 0; i--) begin exv[idx] = st[i]; idx++; end
        f_ne = idx; exv[idx] = ne; idx++;
        f_nw = idx; exv[idx] = nw; idx++;
        f_seq = idx;
        if (ext) begin
            for (int i = 5; i >= 0; i--) begin exv[idx] = 1'((seq_model >> i) & 1); idx++; end
        end
        f_crc = idx;
        c6 = seed[5:0];
        c16 = seed;
        for (int i = 8; i < f_crc; i++) begin
            c6  = {c6[4:0], 1'b0} ^ ((exv[i] ^ c6[5]) ? 6'h03 : 6'h00);
            c16 = {c16[14:0], 1'b0} ^ ((exv[i] ^ c16[15]) ? 16'h90D9 : 16'h0000);
        end
        if (ext) for (int i = 15; i >= 0; i--) begin exv[idx] = c16[i]; idx++; end
        else     for (int i = 5; i >= 0; i--)  begin exv[idx] = c6[i];  idx++; end
        f_end = idx;
        if (nbits < f_end) $display("bench frame too short");
    endtask

    task automatic randomize_inputs();
        mt     = MT_W'($urandom);
        st     = 18'($urandom);
        alm    = $urandom & $urandom & $urandom;
        alm_en = $urandom;
        wrn    = $urandom & $urandom & $urandom;
        wrn_en = $urandom;
    endtask

    task automatic xfer(input logic [7:0] op, input int nbits, input bit perturb);
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            sck  = 1'b0;
            mosi = (k < 8) ? op[7-k] : 1'($urandom);
            repeat (4) @(negedge clk);
            rxv[k] = miso;
            if (k == 3) chk(miso_oe === 1'b1, "R1 oe while selected", {127'b0, miso_oe}, 128'd1);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            if (perturb && k == 0) begin
                randomize_inputs();
                ext  = ~ext;
                sel  = sel + 2'd1;
                seed = ~seed;
            end
        end
        sck = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] op, input bit perturb, input string tag);
        int nbits;
        build(op, 0);
        nbits = (op == 8'hA6) ? f_end + 3 : 30;
        xfer(op, nbits, perturb);
        cmp(0, 8, {"R2 echo ", tag});
        if (op == 8'hA6) begin
            if (perturb) cmp(8, f_end, {"R3 capture at first edge ", tag});
            cmp(f_mt, f_ne, {"R4 position fields ", tag});
            cmp(f_ne, f_ne + 1, {"R5 error flag ", tag});
            cmp(f_nw, f_nw + 1, {"R5 warning flag ", tag});
            if (f_seq != f_crc) cmp(f_seq, f_crc, {"R6 sequence ", tag});
            cmp(f_crc, f_end, {(f_end - f_crc == 16) ? "R8 long crc " : "R7 short crc ", tag});
            cmp(f_end, nbits, {"R10 quiet after crc ", tag});
            seq_model = (seq_model + 1) % 64;
        end else begin
            cmp(8, nbits, {"R9 foreign opcode quiet ", tag});
        end
        chk(miso === 1'b0 && miso_oe === 1'b0, "R1 released after frame",
            {126'b0, miso_oe, miso}, 128'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        mt = '0; st = '0; sel = 2'd0; ext = 1'b0; seed = '0;
        alm = '0; alm_en = '0; wrn = '0; wrn_en = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(miso === 1'b0 && miso_oe === 1'b0, "R1 reset state", {126'b0, miso_oe, miso}, 128'd0);

        // directed: each single-turn width, short format
        for (int s = 0; s < 4; s++) begin
            mt = 16'hA5C3; st = 18'h2_B7E9; sel = 2'(s);
            frame(8'hA6, 1'b0, "width sweep");
        end
        // flags
        alm = 32'h0000_0100; alm_en = 32'h0000_0100; wrn = '0;
        frame(8'hA6, 1'b0, "error active");
        alm_en = 32'hFFFF_FEFF;
        frame(8'hA6, 1'b0, "error masked");
        wrn = 32'h8000_0000; wrn_en = 32'h8000_0000;
        frame(8'hA6, 1'b0, "warning active");
        // long format and seeds
        ext = 1'b1; seed = 16'h0000; sel = 2'd3;
        frame(8'hA6, 1'b0, "long zero seed");
        seed = 16'hBEEF;
        frame(8'hA6, 1'b0, "long seeded");
        ext = 1'b0; seed = 16'h002A;
        frame(8'hA6, 1'b0, "short seeded");
        // foreign opcode must not advance the sequence
        frame(8'h97, 1'b0, "foreign");
        ext = 1'b1;
        frame(8'hA6, 1'b0, "sequence after foreign");
        // late input changes
        randomize_inputs();
        frame(8'hA6, 1'b1, "perturbed");

        // random mix, passes the sequence wrap at 63
        for (int n = 0; n < 75; n++) begin
            randomize_inputs();
            ext  = 1'($urandom);
            sel  = 2'($urandom);
            seed = 16'($urandom);
            if (($urandom % 8) == 0) frame(8'($urandom) | 8'h01, 1'b0, "random foreign");
            else                     frame(8'hA6, 1'b0, "random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule